// File: doc/BRIEF.md
# Wildcard Flow Table Matcher

This block holds a table of flow entries and classifies parsed packet headers against it. Each entry has a match rule over twelve header fields, a don't-care bit for each field, an action word, a valid flag and a saturating hit counter. One header tuple enters per clock on a valid/ready handshake. The block compares it against every valid entry in parallel and reports either the winning entry's index and action, or a miss that tells downstream logic to hand the frame to the controller rather than forward it.

A controller-side write port installs an entry into a slot, overwrites it, or invalidates it. A read port returns any slot's hit counter. New entries can be installed while traffic runs, so later frames of a flow hit the table instead of missing. Header parsing, frame storage, the controller protocol and the execution of actions are done by other blocks.

Top module: `flow_match_table`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, every counter reads 0 and `res_valid` is 0.
- R2: An entry with no don't-care bits matches only a key that equals its rule in all twelve fields. A difference in any one field makes that entry not match.
- R3: Bit f of a wildcard mask set to 1 makes field f ignored in the comparison. The bit-to-field mapping is: 0 ingress port, 1 Ethernet source, 2 Ethernet destination, 3 Ethernet type, 4 VLAN id, 5 VLAN priority, 6 IP source, 7 IP destination, 8 IP protocol, 9 IP ToS, 10 L4 source port, 11 L4 destination port.
- R4: When several valid entries match, the result reports the entry with the lowest index.
- R5: A key that matches no valid entry gives `res_miss`=1, `res_index`=0 and `res_action`=0.
- R6: On a hit, `res_action` is the installed action word, returned unchanged. Its layout is bits [29:28] kind (0 = send to one port, 1 = send to all ports, 2 = add VLAN tag then send to one port), bits [27:12] output port and bits [11:0] VLAN id.
- R7: `key_ready` is always 1. A key accepted in cycle t gives `res_valid`=1 in cycle t+2. Back-to-back keys give back-to-back results in order.
- R8: Each hit adds 1 to the winning entry's counter. `ctl_rd_count` shows the counter of `ctl_rd_idx` one cycle after the index is applied.
- R9: A counter at its maximum value stays at that value on further hits.
- R10: Installing into a slot clears that slot's counter. Invalidating a slot makes it stop matching.
- R11: A lookup accepted in the same cycle as a write to an entry sees the entry's contents from before the write.
- R12: An entry installed at run time is hit by the next key of that flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Header tuple present |
| key_ready | output | 1 | Always 1; the pipeline never stalls |
| key_in | input | 253 | Packed header tuple (see `hdr_key_t`) |
| res_valid | output | 1 | Lookup result present |
| res_miss | output | 1 | No entry matched; send the frame to the controller |
| res_index | output | IDX_W | Winning entry index (0 on a miss) |
| res_action | output | 30 | Winning action word (0 on a miss) |
| ctl_wr_en | input | 1 | Table write strobe |
| ctl_wr_install | input | 1 | 1 installs or overwrites the slot, 0 invalidates it |
| ctl_wr_idx | input | IDX_W | Slot to write |
| ctl_wr_key | input | 253 | Rule fields to install |
| ctl_wr_wild | input | 12 | Per-field don't-care bits to install |
| ctl_wr_action | input | 30 | Action word to install |
| ctl_rd_idx | input | IDX_W | Slot whose counter is read |
| ctl_rd_count | output | CNT_W | Counter of the selected slot, registered |

## Verification
A key driven before clock edge t is compared at that edge and its result appears after edge t+1. The bench therefore streams keys from a vector table and checks the outputs at each falling edge for the key issued two iterations earlier. Counter updates land at the same edge as the compare, and the counter read path adds one register. So counters are read one full cycle after the index is applied, and only after the lookups that feed them have been issued. The same-cycle write check issues the write and the key at one edge and expects the miss from the old table two cycles later.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int NUM_FIELDS = 12;

    typedef struct packed {
        logic [15:0] in_port;
        logic [47:0] eth_src;
        logic [47:0] eth_dst;
        logic [15:0] eth_type;
        logic [11:0] vlan_id;
        logic [2:0]  vlan_pcp;
        logic [31:0] ip_src;
        logic [31:0] ip_dst;
        logic [7:0]  ip_proto;
        logic [5:0]  ip_tos;
        logic [15:0] l4_src;
        logic [15:0] l4_dst;
    } hdr_key_t;

    localparam int KEY_W = $bits(hdr_key_t);

    typedef enum logic [1:0] {
        ACT_OUT_PORT  = 2'd0,
        ACT_ALL_PORTS = 2'd1,
        ACT_VLAN_OUT  = 2'd2
    } act_kind_e;

    typedef struct packed {
        act_kind_e   kind;
        logic [15:0] port;
        logic [11:0] vlan;
    } act_t;

    localparam int ACT_W = $bits(act_t);

    // One bit per field, set where the two tuples disagree
    function automatic logic [NUM_FIELDS-1:0] field_diff(hdr_key_t a, hdr_key_t b);
        logic [NUM_FIELDS-1:0] d;
        d[0]  = a.in_port  != b.in_port;
        d[1]  = a.eth_src  != b.eth_src;
        d[2]  = a.eth_dst  != b.eth_dst;
        d[3]  = a.eth_type != b.eth_type;
        d[4]  = a.vlan_id  != b.vlan_id;
        d[5]  = a.vlan_pcp != b.vlan_pcp;
        d[6]  = a.ip_src   != b.ip_src;
        d[7]  = a.ip_dst   != b.ip_dst;
        d[8]  = a.ip_proto != b.ip_proto;
        d[9]  = a.ip_tos   != b.ip_tos;
        d[10] = a.l4_src   != b.l4_src;
        d[11] = a.l4_dst   != b.l4_dst;
        return d;
    endfunction

endpackage

// File: rtl/flow_entry_store.sv
module flow_entry_store
    import flow_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_install,
    input  logic [IDX_W-1:0]      wr_idx,
    input  hdr_key_t              wr_key,
    input  logic [NUM_FIELDS-1:0] wr_wild,
    input  act_t                  wr_act,
    input  hdr_key_t              lk_key,
    input  logic [IDX_W-1:0]      sel_idx,
    output logic [DEPTH-1:0]      hit_vec,
    output act_t                  sel_act
);

    hdr_key_t              rule_q  [DEPTH];
    logic [NUM_FIELDS-1:0] wild_q  [DEPTH];
    act_t                  act_q   [DEPTH];
    logic                  valid_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic slot_wr;
        assign slot_wr = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (slot_wr) begin
                valid_q[i] <= wr_install;
            end
            if (slot_wr && wr_install) begin
                rule_q[i] <= wr_key;
                wild_q[i] <= wr_wild;
                act_q[i]  <= wr_act;
            end
        end

        // Match: valid and no disagreeing field that is not a don't-care
        assign hit_vec[i] = valid_q[i] &&
                            ~|(field_diff(rule_q[i], lk_key) & ~wild_q[i]);

        AST_INVALIDATED_NO_HIT: assert property (@(posedge clk) disable iff (rst)
            slot_wr && !wr_install |=> !hit_vec[i]); // R10
    end

    assign sel_act = act_q[sel_idx];

endmodule

// File: rtl/flow_prio_enc.sv
module flow_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/flow_hit_counters.sv
module flow_hit_counters #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cnt
        logic clr_me, inc_me;
        assign clr_me = clr_en && (clr_idx == IDX_W'(i));
        assign inc_me = inc_en && (inc_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr_me) begin
                cnt_q[i] <= '0;
            end else if (inc_me && (cnt_q[i] != CNT_MAX)) begin
                cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end

        AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[i] == CNT_MAX) && !clr_me |=> cnt_q[i] == CNT_MAX); // R9

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
            !clr_me |=> (cnt_q[i] == $past(cnt_q[i])) ||
                        (cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1))); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) rd_count <= '0;
        else     rd_count <= cnt_q[rd_idx];
    end

endmodule

// File: rtl/flow_match_table.sv
module flow_match_table
    import flow_pkg::*;
#(
    parameter int  DEPTH = 16,
    parameter int  CNT_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  key_valid,
    output logic                  key_ready,
    input  logic [KEY_W-1:0]      key_in,
    output logic                  res_valid,
    output logic                  res_miss,
    output logic [IDX_W-1:0]      res_index,
    output logic [ACT_W-1:0]      res_action,
    input  logic                  ctl_wr_en,
    input  logic                  ctl_wr_install,
    input  logic [IDX_W-1:0]      ctl_wr_idx,
    input  logic [KEY_W-1:0]      ctl_wr_key,
    input  logic [NUM_FIELDS-1:0] ctl_wr_wild,
    input  logic [ACT_W-1:0]      ctl_wr_action,
    input  logic [IDX_W-1:0]      ctl_rd_idx,
    output logic [CNT_W-1:0]      ctl_rd_count
);

    logic [DEPTH-1:0] hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    act_t             win_act;
    logic             accept;

    assign key_ready = 1'b1;
    assign accept    = key_valid;

    flow_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctl_wr_en),
        .wr_install (ctl_wr_install),
        .wr_idx     (ctl_wr_idx),
        .wr_key     (hdr_key_t'(ctl_wr_key)),
        .wr_wild    (ctl_wr_wild),
        .wr_act     (act_t'(ctl_wr_action)),
        .lk_key     (hdr_key_t'(key_in)),
        .sel_idx    (win_idx),
        .hit_vec    (hit_vec),
        .sel_act    (win_act)
    );

    flow_prio_enc #(.N(DEPTH), .IDX_W(IDX_W)) enc_i (
        .vec (hit_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    flow_hit_counters #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (accept && any_hit),
        .inc_idx  (win_idx),
        .clr_en   (ctl_wr_en && ctl_wr_install),
        .clr_idx  (ctl_wr_idx),
        .rd_idx   (ctl_rd_idx),
        .rd_count (ctl_rd_count)
    );

    // Stage 1: compare and select against the table as it stands before this edge
    logic             s1_valid, s1_hit;
    logic [IDX_W-1:0] s1_idx;
    act_t             s1_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_idx   <= '0;
            s1_act   <= '0;
        end else begin
            s1_valid <= accept;
            s1_hit   <= accept && any_hit;
            s1_idx   <= (accept && any_hit) ? win_idx : '0;
            s1_act   <= (accept && any_hit) ? win_act : act_t'('0);
        end
    end

    // Stage 2: result register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_miss   <= 1'b0;
            res_index  <= '0;
            res_action <= '0;
        end else begin
            res_valid  <= s1_valid;
            res_miss   <= s1_valid && !s1_hit;
            res_index  <= s1_idx;
            res_action <= s1_act;
        end
    end

    logic [DEPTH-1:0] below_win;
    assign below_win = (DEPTH'(1) << win_idx) - DEPTH'(1);

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> hit_vec[win_idx] && ((hit_vec & below_win) == '0)); // R4

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_miss |-> (res_index == '0) && (res_action == '0)); // R5

    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ##2 res_valid); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !key_valid |-> ##2 !res_valid); // R7

endmodule

// File: tb/flow_match_table_tb.sv
module flow_match_table_tb_top;
    import flow_pkg::*;

    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(DEPTH);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  key_valid = 1'b0;
    logic                  key_ready;
    logic [KEY_W-1:0]      key_in = '0;
    logic                  res_valid, res_miss;
    logic [IDX_W-1:0]      res_index;
    logic [ACT_W-1:0]      res_action;
    logic                  ctl_wr_en = 1'b0;
    logic                  ctl_wr_install = 1'b0;
    logic [IDX_W-1:0]      ctl_wr_idx = '0;
    logic [KEY_W-1:0]      ctl_wr_key = '0;
    logic [NUM_FIELDS-1:0] ctl_wr_wild = '0;
    logic [ACT_W-1:0]      ctl_wr_action = '0;
    logic [IDX_W-1:0]      ctl_rd_idx = '0;
    logic [CNT_W-1:0]      ctl_rd_count;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    flow_match_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (.*);

    typedef struct packed {
        logic [3:0]       sel;
        logic             miss;
        logic [IDX_W-1:0] idx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 3'd2}, '{4'd1, 1'b0, 3'd5}, '{4'd2, 1'b0, 3'd7},
        '{4'd3, 1'b1, 3'd0}, '{4'd4, 1'b0, 3'd5}, '{4'd0, 1'b0, 3'd2}
    };

    localparam act_t A0 = '{ACT_OUT_PORT,  16'd9, 12'd0};
    localparam act_t A2 = '{ACT_OUT_PORT,  16'd5, 12'd0};
    localparam act_t A5 = '{ACT_ALL_PORTS, 16'd0, 12'd0};
    localparam act_t A7 = '{ACT_VLAN_OUT,  16'd3, 12'h123};

    function automatic hdr_key_t mk_key(int sel);
        hdr_key_t k;
        k.in_port  = 16'd3;
        k.eth_src  = 48'h0A0B0C0D0E0F;
        k.eth_dst  = 48'h112233445566;
        k.eth_type = 16'h0800;
        k.vlan_id  = 12'd100;
        k.vlan_pcp = 3'd5;
        k.ip_src   = 32'h0A000001;
        k.ip_dst   = 32'h0A000002;
        k.ip_proto = 8'd6;
        k.ip_tos   = 6'd4;
        k.l4_src   = 16'd1234;
        k.l4_dst   = 16'd80;
        case (sel)
            1: k.l4_dst = 16'd81;
            2: k.eth_type = 16'h86DD;
            3: begin k.eth_type = 16'h86DD; k.vlan_id = 12'd200; end
            4: k.in_port = 16'd7;
            default: ;
        endcase
        return k;
    endfunction

    function automatic act_t act_of(logic [IDX_W-1:0] idx);
        case (idx)
            3'd0: return A0;
            3'd2: return A2;
            3'd5: return A5;
            3'd7: return A7;
            default: return '0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_entry(int idx, bit install, hdr_key_t k, logic [11:0] wild, act_t a);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_install = install; ctl_wr_idx = IDX_W'(idx);
        ctl_wr_key = k; ctl_wr_wild = wild; ctl_wr_action = a;
        @(posedge clk);
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic check_result(bit miss, logic [IDX_W-1:0] idx, string tag);
        act_t ea;
        ea = miss ? act_t'('0) : act_of(idx);
        check(res_valid == 1'b1, {tag, " valid"}, longint'(res_valid), 1);
        check(res_miss == miss, {tag, " miss"}, longint'(res_miss), longint'(miss));
        check(res_index == (miss ? '0 : idx), {tag, " index"}, longint'(res_index),
              longint'(miss ? '0 : idx));
        check(res_action == ea, {tag, " action"}, longint'(res_action), longint'(ea));
    endtask

    task automatic lookup(int sel, bit miss, logic [IDX_W-1:0] idx, string tag);
        @(negedge clk);
        key_in = mk_key(sel); key_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_result(miss, idx, tag);
    endtask

    task automatic read_cnt(int idx, int exp, string tag);
        @(negedge clk);
        ctl_rd_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        check(ctl_rd_count == CNT_W'(exp), tag, longint'(ctl_rd_count), longint'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid in reset", longint'(res_valid), 0);
        rst = 1'b0;

        // R1: empty table misses, counters zero
        lookup(0, 1'b1, '0, "R1 empty lookup");
        read_cnt(2, 0, "R1 counter after reset");

        // Populate: exact rule, eth_type-only rule, vlan-only rule
        wr_entry(2, 1'b1, mk_key(0), 12'h000, A2);
        begin
            hdr_key_t r5;
            hdr_key_t r7;
            r5 = mk_key(0); r5.ip_src = 32'hDEADBEEF;
            r7 = '0; r7.vlan_id = 12'd100;
            wr_entry(5, 1'b1, r5, 12'hFF7, A5);
            wr_entry(7, 1'b1, r7, 12'hFEF, A7);
        end

        // R2 R3 R4 R5 R6 R7: streamed vector table, one key per cycle
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check_result(VECS[i-2].miss, VECS[i-2].idx,
                             $sformatf("R2 R3 R4 R6 R7 vector %0d", i - 2));
            end
            if (i < NV) begin
                key_in = mk_key(int'(VECS[i].sel)); key_valid = 1'b1;
            end else begin
                key_valid = 1'b0;
            end
            @(posedge clk);
        end

        // R8: counts from the vector table
        read_cnt(2, 2, "R8 count entry 2");
        read_cnt(5, 2, "R8 count entry 5");
        read_cnt(7, 1, "R8 count entry 7");

        // R9: saturate entry 2
        for (int n = 0; n < 15; n++) lookup(0, 1'b0, 3'd2, "R9 repeat hit");
        read_cnt(2, 15, "R9 saturated");

        // R10: reinstall clears counter, invalidate stops matching
        wr_entry(2, 1'b1, mk_key(0), 12'h000, A2);
        read_cnt(2, 0, "R10 counter cleared on install");
        wr_entry(5, 1'b0, mk_key(0), 12'h000, A5);
        lookup(1, 1'b0, 3'd7, "R10 invalidated entry skipped");

        // R11: write and lookup in the same cycle see old contents
        @(negedge clk);
        key_in = mk_key(3); key_valid = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_install = 1'b1; ctl_wr_idx = 3'd0;
        ctl_wr_key = mk_key(3); ctl_wr_wild = 12'h000; ctl_wr_action = A0;
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0; ctl_wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_result(1'b1, '0, "R11 same-cycle write");

        // R12: installed flow hits afterwards
        lookup(3, 1'b0, 3'd0, "R12 runtime install hit");
        read_cnt(0, 1, "R12 counter of new entry");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule